// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches eight general-purpose input pins and turns selected pin activity into interrupt requests. Each pin is first passed through a two-stage synchroniser. A per-pin trigger mode then selects how the pin drives its status bit. The bit can follow a high or low level, be forced on, or latch a rising, falling or any edge until software clears it.

Software reaches the block through a small synchronous register bus. The bus carries an address, a write strobe, 32-bit write data and 32-bit read data that is registered. Through this bus software programs the trigger modes and a per-pin enable mask, reads raw and masked status, and clears latched edges by writing ones to an acknowledge location. A single registered interrupt line is high whenever any enabled status bit is set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mode word, the mask and all status bits are zero, irq_o is low, and every readable register returns zero.
- R2: The mode word at offset 12 holds 3 bits per pin, pin n in bits [3n+2:3n]. Bits [31:24] are not stored and read as zero.
- R3: In mode 1 the raw bit is high while the synchronised pin is high. In mode 2 it is high while the pin is low. A pin change reaches the raw status two clock edges after it is sampled.
- R4: Mode 3 forces the raw bit to 1. Modes 0 and 4 force it to 0 and discard any latched edge.
- R5: Mode 5 latches rising edges, mode 6 falling edges and mode 7 both. An edge is a change of the synchronised pin between consecutive cycles, and a latched bit stays set after the pin returns.
- R6: A write to offset 20 clears each latched edge bit whose data bit [n] is 1. A 0 bit leaves its bit unchanged, and level-mode and forced bits are not affected.
- R7: When a new edge and an acknowledge for the same pin fall in the same cycle, the bit stays set.
- R8: The mask is at offset 16 (bit n enables pin n). Raw status is at offset 24 and masked status at offset 28, and masked status equals raw AND mask.
- R9: irq_o is the OR of the masked status bits, registered, so it follows the status one cycle later.
- R10: Writes to offsets 24 and 28 have no effect. Reads of offset 20 and of any unmapped offset return zero.
- R11: Read data reflects the address presented in the previous cycle and the register values before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin inputs |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A latch that is stuck or lost shows up as a wrong bit in the raw status read, one cycle after offset 24 is addressed. It also shows on irq_o one cycle after the masked status changes. A synchroniser with the wrong depth, or an edge detector that compares the wrong samples, moves every status change by a whole cycle, so checking each cycle against a cycle-level model exposes it at once. A wrong acknowledge priority only appears when an edge and an acknowledge coincide, so that case is driven on purpose as well as by random traffic.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF   = 3'd0,
    TRIG_HIGH  = 3'd1,
    TRIG_LOW   = 3'd2,
    TRIG_FORCE = 3'd3,
    TRIG_RSVD  = 3'd4,
    TRIG_RISE  = 3'd5,
    TRIG_FALL  = 3'd6,
    TRIG_BOTH  = 3'd7
  } trig_mode_e;

  localparam logic [7:0] OFS_CFG  = 8'd12;
  localparam logic [7:0] OFS_MASK = 8'd16;
  localparam logic [7:0] OFS_ACK  = 8'd20;
  localparam logic [7:0] OFS_RAW  = 8'd24;
  localparam logic [7:0] OFS_MSKD = 8'd28;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,   // synchronised pin
  input  trig_mode_e mode_i,
  input  logic       ack_i,
  output logic       raw_o
);
  logic prev_q, raw_q, raw_d;
  logic rise, fall, hit, edge_mode;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign edge_mode = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL) || (mode_i == TRIG_BOTH);

  always_comb begin
    case (mode_i)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    case (mode_i)
      TRIG_HIGH:  raw_d = lvl_i;
      TRIG_LOW:   raw_d = ~lvl_i;
      TRIG_FORCE: raw_d = 1'b1;
      TRIG_RISE, TRIG_FALL, TRIG_BOTH:
                  raw_d = hit | (raw_q & ~ack_i);  // new edge beats ack
      default:    raw_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      raw_q  <= raw_d;
    end
  end

  assign raw_o = raw_q;

  assert_force_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_FORCE) |=> raw_q);
  assert_off_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_OFF || mode_i == TRIG_RSVD) |=> !raw_q);
  assert_edge_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && hit) |=> raw_q);
  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && ack_i && !hit) |=> !raw_q);
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && raw_q && !ack_i) |=> raw_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CFG_W = NPINS * MODE_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [NPINS-1:0]  mask_q, ack_vec, lvl, raw_vec, masked;
  logic [DATA_W-1:0] rd_d, rdata_q;
  logic              irq_q;
  logic              sel_cfg, sel_mask, sel_ack;

  assign sel_cfg  = addr_i == ADDR_W'(OFS_CFG);
  assign sel_mask = addr_i == ADDR_W'(OFS_MASK);
  assign sel_ack  = addr_i == ADDR_W'(OFS_ACK);
  assign ack_vec  = (wr_en_i && sel_ack) ? wdata_i[NPINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      if (sel_cfg)  cfg_q  <= wdata_i[CFG_W-1:0];
      if (sel_mask) mask_q <= wdata_i[NPINS-1:0];
    end
  end

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_irq_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl[g]),
      .mode_i(trig_mode_e'(cfg_q[g*MODE_W +: MODE_W])),
      .ack_i (ack_vec[g]),
      .raw_o (raw_vec[g])
    );
  end

  assign masked = raw_vec & mask_q;

  always_comb begin
    rd_d = '0;
    if (sel_cfg)                          rd_d = DATA_W'(cfg_q);
    else if (sel_mask)                    rd_d = DATA_W'(mask_q);
    else if (addr_i == ADDR_W'(OFS_RAW))  rd_d = DATA_W'(raw_vec);
    else if (addr_i == ADDR_W'(OFS_MSKD)) rd_d = DATA_W'(masked);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_d;
      irq_q   <= |masked;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(raw_vec & mask_q)));
  assert_mask_gates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_q) == '0) |-> !irq_o);
  assert_ack_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ack |=> (rdata_o == '0));
  assert_cfg_top_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cfg |=> (rdata_o[DATA_W-1:CFG_W] == '0));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";
  logic [7:0] pin_cur = '0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .addr_i(addr),
    .wr_en_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // cycle-level reference built from the requirements
  logic [7:0]  m_s1, m_s2, m_sp, m_mask, m_raw, m_ack;
  logic [23:0] m_cfg;
  logic [31:0] m_rd;
  logic        m_irq;

  function automatic logic ref_raw(logic [2:0] md, logic s, logic sp, logic r, logic ak);
    logic rs, fl;
    rs = s & ~sp;
    fl = ~s & sp;
    case (md)
      3'd1: return s;
      3'd2: return ~s;
      3'd3: return 1'b1;
      3'd5: return rs | (r & ~ak);
      3'd6: return fl | (r & ~ak);
      3'd7: return rs | fl | (r & ~ak);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(logic [7:0] a);
    case (a)
      8'd12: return {8'h0, m_cfg};
      8'd16: return {24'h0, m_mask};
      8'd24: return {24'h0, m_raw};
      8'd28: return {24'h0, m_raw & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  assign m_ack = (we && addr == 8'd20) ? wdata[7:0] : 8'h0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_sp <= '0; m_raw <= '0;
      m_cfg <= '0; m_mask <= '0; m_rd <= '0; m_irq <= 1'b0;
    end else begin
      m_s1 <= pin; m_s2 <= m_s1; m_sp <= m_s2;
      for (int i = 0; i < 8; i++)
        m_raw[i] <= ref_raw(m_cfg[3*i +: 3], m_s2[i], m_sp[i], m_raw[i], m_ack[i]);
      m_irq <= |(m_raw & m_mask);
      m_rd  <= ref_read(addr);
      if (we && addr == 8'd12) m_cfg  <= wdata[23:0];
      if (we && addr == 8'd16) m_mask <= wdata[7:0];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    chk(tag, "irq_o vs model", {31'h0, irq}, {31'h0, m_irq});
    chk(tag, "rdata_o vs model", rdata, m_rd);
    addr = a; we = w; wdata = d; pin = pin_cur;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(a, 1'b1, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(8'd0, 1'b0, 32'h0);
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp);
    step(a, 1'b0, 32'h0);
    @(posedge clk); #5;
    chk(tag, "read value", rdata, exp);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    rd_expect(8'd12, 32'h0);
    rd_expect(8'd16, 32'h0);
    rd_expect(8'd24, 32'h0);
    rd_expect(8'd28, 32'h0);
    chk("R1", "irq after reset", {31'h0, irq}, 32'h0);

    tag = "R2";
    wr(8'd12, 32'hFFFA_C688);
    rd_expect(8'd12, 32'h00FA_C688);
    wr(8'd12, 32'h0);
    tag = "R11";
    rd_expect(8'd12, 32'h0);

    tag = "R3";
    wr(8'd12, 32'h11);            // pin0 high-level, pin1 low-level
    idle(4);
    rd_expect(8'd24, 32'h2);
    pin_cur = 8'h03;
    idle(4);
    rd_expect(8'd24, 32'h1);

    tag = "R4";
    pin_cur = 8'h00;
    wr(8'd12, 32'h8C0);           // pin2 forced, pin3 mode 4
    idle(3);
    rd_expect(8'd24, 32'h4);
    wr(8'd12, 32'h5000);          // pin4 rising
    idle(3);
    pin_cur = 8'h10;
    idle(4);
    rd_expect(8'd24, 32'h10);
    wr(8'd12, 32'h0);
    idle(2);
    rd_expect(8'd24, 32'h0);

    tag = "R5";
    pin_cur = 8'hE0;
    idle(4);
    wr(8'd12, 32'hBF0000);        // pin5 falling, pin6 both, pin7 rising
    idle(3);
    rd_expect(8'd24, 32'h0);
    pin_cur = 8'h00;
    idle(4);
    rd_expect(8'd24, 32'h60);
    pin_cur = 8'h80;
    idle(4);
    rd_expect(8'd24, 32'hE0);
    pin_cur = 8'h00;
    idle(4);
    rd_expect(8'd24, 32'hE0);

    tag = "R6";
    wr(8'd20, 32'h20);
    idle(2);
    rd_expect(8'd24, 32'hC0);
    wr(8'd20, 32'h0);
    idle(2);
    rd_expect(8'd24, 32'hC0);
    wr(8'd12, 32'hBF0001);        // add pin0 high-level
    pin_cur = 8'h01;
    idle(4);
    wr(8'd20, 32'hFF);
    rd_expect(8'd24, 32'h01);

    tag = "R7";
    pin_cur = 8'h81;
    idle(1);
    idle(1);
    wr(8'd20, 32'h80);            // ack lands on the edge cycle
    idle(2);
    rd_expect(8'd24, 32'h81);

    tag = "R8";
    wr(8'd16, 32'h0F);
    idle(1);
    rd_expect(8'd16, 32'h0F);
    rd_expect(8'd28, 32'h01);

    tag = "R9";
    idle(1);
    chk("R9", "irq with enabled bit", {31'h0, irq}, 32'h1);
    wr(8'd16, 32'h0);
    idle(2);
    chk("R9", "irq after mask clear", {31'h0, irq}, 32'h0);

    tag = "R10";
    wr(8'd24, 32'hFF);
    wr(8'd28, 32'hFF);
    rd_expect(8'd24, 32'h81);
    rd_expect(8'd20, 32'h0);
    rd_expect(8'd4, 32'h0);

    tag = "RND";
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic w;
      case ($urandom % 8)
        0: a = 8'd12; 1: a = 8'd16; 2: a = 8'd20; 3: a = 8'd24;
        4: a = 8'd28; 5: a = 8'd24; 6: a = 8'd28; default: a = 8'(($urandom % 16) * 4);
      endcase
      w = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) pin_cur = 8'($urandom);
      step(a, w, $urandom);
    end
    idle(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule